// File: doc/BRIEF.md
# Dual-Strobe Up/Down Decade Counter

A 4-bit presettable counter with two count strobes. One strobe steps the count up and the other steps it down. A rising edge on the up strobe adds one, but only while the down strobe rests high. A rising edge on the down strobe subtracts one, but only while the up strobe rests high. A build parameter selects either a decade sequence (0 to 9) or a full binary sequence (0 to 15).

The whole block runs on one free-running system clock. Each strobe passes through a two-flop synchronizer, and a step is taken in the cycle after a synchronized rising edge is seen. A synchronous master clear and a level-sensitive, active-low parallel load act at every system clock edge as priority overrides. Clear wins over load, and load wins over counting.

Two active-low terminal outputs, carry and borrow, are shaped so that they can drive the strobes of a following stage directly. Carry is low while the synchronized up strobe is low and the count sits at its top value. Borrow is low while the synchronized down strobe is low and the count sits at zero. Wiring carry to the next stage's up strobe and borrow to its down strobe chains stages into a multi-digit counter.

Top module: `dual_strobe_counter`

## Requirements
- R1: While rstN is low, countQ is 0 and both carryN and borrowN are 1.
- R2: A rising edge on upStrobe while downStrobe is high adds one to countQ. The new value appears on the third rising clk edge after the strobe rise is first sampled.
- R3: A rising edge on downStrobe while upStrobe is high subtracts one from countQ, with the same three-edge latency.
- R4: A rising edge on one strobe while the other strobe is low leaves countQ unchanged.
- R5: When synchronized rising edges of both strobes are seen in the same cycle, countQ holds.
- R6: masterClr high sets countQ to 0 at the next clk edge, whatever loadN and the strobes are doing.
- R7: While loadN is low and masterClr is low, countQ takes presetVal at every clk edge, and strobe edges have no effect.
- R8: Counting wraps at the ends. The top value is 9 when DECADE is 1 and 15 when DECADE is 0. Counting up from the top value gives 0, and counting down from 0 gives the top value.
- R9: carryN is 0 exactly when the synchronized up strobe is low and countQ equals the top value. Otherwise it is 1.
- R10: borrowN is 0 exactly when the synchronized down strobe is low and countQ is 0. Otherwise it is 1.
- R11: With DECADE=1, a count of 10 to 15 steps to 0 when counted up and to 9 when counted down.
- R12: Two decade stages, with the first stage's carryN driving the second stage's upStrobe and its borrowN driving the second stage's downStrobe, hold the correct units and tens digits of the net number of up and down steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| upStrobe | input | 1 | Count-up strobe; steps on a rising edge |
| downStrobe | input | 1 | Count-down strobe; steps on a rising edge |
| masterClr | input | 1 | Active-high clear, highest priority |
| loadN | input | 1 | Active-low parallel load |
| presetVal | input | WIDTH | Value taken while loading |
| countQ | output | WIDTH | Current count |
| carryN | output | 1 | Active-low terminal count when counting up |
| borrowN | output | 1 | Active-low terminal count when counting down |

## Verification
The cases that are hardest to reach from the ports are the illegal decade states and two strobe edges that become visible in the same synchronized cycle. The bench reaches the illegal states by loading 12, 14 and 15 and then stepping once. It produces coincident edges by dropping both strobes together and raising them on the same clock. The borrow ripple across a digit boundary, from 20 to 19, only arises in a chain of stages. The bench therefore builds a two-stage cascade, counts it up past several decades and then back down across a tens boundary.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // One-hot (or idle) step command from control to datapath
  typedef struct packed {
    logic clr;
    logic load;
    logic inc;
    logic dec;
  } stepCmd_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic strobeIn,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prevLvl;

  // Strobes idle high, so reset to high to avoid a false edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain   <= '1;
      prevLvl <= 1'b1;
    end else begin
      chain   <= {chain[STAGES-2:0], strobeIn};
      prevLvl <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prevLvl;
endmodule

// File: rtl/strobe_ctrl.sv
module strobe_ctrl
  import dsc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     upStrobe,
  input  logic     downStrobe,
  input  logic     masterClr,
  input  logic     loadN,
  output logic     upLvl,
  output logic     downLvl,
  output stepCmd_t cmd
);
  logic upRise;
  logic downRise;

  edge_sync #(.STAGES(SYNC_STAGES)) u_upSync (
    .clk(clk), .rstN(rstN), .strobeIn(upStrobe),
    .lvl(upLvl), .rise(upRise)
  );

  edge_sync #(.STAGES(SYNC_STAGES)) u_downSync (
    .clk(clk), .rstN(rstN), .strobeIn(downStrobe),
    .lvl(downLvl), .rise(downRise)
  );

  // Priority: clear, then load, then a single qualified step
  always_comb begin
    cmd = '0;
    if (masterClr) begin
      cmd.clr = 1'b1;
    end else if (!loadN) begin
      cmd.load = 1'b1;
    end else if (upRise && !downRise && downLvl) begin
      cmd.inc = 1'b1;
    end else if (downRise && !upRise && upLvl) begin
      cmd.dec = 1'b1;
    end
  end
endmodule

// File: rtl/count_datapath.sv
module count_datapath
  import dsc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCmd_t         cmd,
  input  logic [WIDTH-1:0] presetVal,
  input  logic             upLvl,
  input  logic             downLvl,
  output logic [WIDTH-1:0] countQ,
  output logic             carryN,
  output logic             borrowN
);
  localparam logic [WIDTH-1:0] TOP_VAL = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  logic [WIDTH-1:0] incVal;
  logic [WIDTH-1:0] decVal;
  logic [WIDTH-1:0] nextCount;

  generate
    if (DECADE) begin : g_decade
      // Anything at or above the top (including illegal codes) goes to zero
      assign incVal = (countQ >= TOP_VAL) ? '0 : countQ + 1'b1;
      assign decVal = (countQ == '0)     ? TOP_VAL :
                      (countQ > TOP_VAL) ? TOP_VAL : countQ - 1'b1;
    end else begin : g_binary
      assign incVal = countQ + 1'b1;
      assign decVal = countQ - 1'b1;
    end
  endgenerate

  always_comb begin
    nextCount = countQ;
    if (cmd.clr)       nextCount = '0;
    else if (cmd.load) nextCount = presetVal;
    else if (cmd.inc)  nextCount = incVal;
    else if (cmd.dec)  nextCount = decVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else       countQ <= nextCount;
  end

  assign carryN  = ~(~upLvl   && (countQ == TOP_VAL));
  assign borrowN = ~(~downLvl && (countQ == '0));
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upStrobe,
  input  logic             downStrobe,
  input  logic             masterClr,
  input  logic             loadN,
  input  logic [WIDTH-1:0] presetVal,
  output logic [WIDTH-1:0] countQ,
  output logic             carryN,
  output logic             borrowN
);
  stepCmd_t cmd;
  logic     upLvl;
  logic     downLvl;

  strobe_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .upStrobe(upStrobe), .downStrobe(downStrobe),
    .masterClr(masterClr), .loadN(loadN),
    .upLvl(upLvl), .downLvl(downLvl), .cmd(cmd)
  );

  count_datapath #(.WIDTH(WIDTH), .DECADE(DECADE)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .presetVal(presetVal),
    .upLvl(upLvl), .downLvl(downLvl),
    .countQ(countQ), .carryN(carryN), .borrowN(borrowN)
  );
endmodule

// File: rtl/dual_strobe_counter_chk.sv
module dual_strobe_counter_chk
  import dsc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             masterClr,
  input logic             loadN,
  input logic [WIDTH-1:0] presetVal,
  input logic [WIDTH-1:0] countQ,
  input logic             carryN,
  input logic             borrowN,
  input stepCmd_t         cmd
);
  localparam logic [WIDTH-1:0] TOP_VAL = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    masterClr |=> countQ == '0);

  assert_load_preset_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!masterClr && !loadN) |=> countQ == $past(presetVal));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmd));

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.inc && countQ < TOP_VAL) |=> countQ == $past(countQ) + 1'b1);

  assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.dec && countQ != '0 && countQ <= TOP_VAL) |=> countQ == $past(countQ) - 1'b1);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == '0) |=> $stable(countQ));

  assert_carry_at_top_R9: assert property (@(posedge clk) disable iff (!rstN)
    !carryN |-> countQ == TOP_VAL);

  assert_borrow_at_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !borrowN |-> countQ == '0);

  assert_back_in_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.inc || cmd.dec) |=> countQ <= TOP_VAL);
endmodule

bind dual_strobe_counter dual_strobe_counter_chk #(.WIDTH(WIDTH), .DECADE(DECADE)) u_chk (
  .clk(clk), .rstN(rstN), .masterClr(masterClr), .loadN(loadN),
  .presetVal(presetVal), .countQ(countQ), .carryN(carryN),
  .borrowN(borrowN), .cmd(cmd)
);

// File: tb/test_dual_strobe_counter.sv
module test_dual_strobe_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upS = 1'b1, downS = 1'b1, clrS = 1'b0, loadS = 1'b1;
  logic [3:0] presetS = '0;
  logic [3:0] cntA, cntB;
  logic carA, borA, carB, borB;

  logic cUp = 1'b1, cDown = 1'b1, cClr = 1'b0;
  logic [3:0] dig0, dig1;
  logic car0, bor0, car1, bor1;

  int checks = 0, errors = 0;
  string reqTag = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_strobe_counter #(.WIDTH(4), .DECADE(1'b1)) i_dual_strobe_counter (
    .clk(clk), .rstN(rstN), .upStrobe(upS), .downStrobe(downS),
    .masterClr(clrS), .loadN(loadS), .presetVal(presetS),
    .countQ(cntA), .carryN(carA), .borrowN(borA));

  dual_strobe_counter #(.WIDTH(4), .DECADE(1'b0)) i_dual_strobe_counter_bin (
    .clk(clk), .rstN(rstN), .upStrobe(upS), .downStrobe(downS),
    .masterClr(clrS), .loadN(loadS), .presetVal(presetS),
    .countQ(cntB), .carryN(carB), .borrowN(borB));

  // Two-digit cascade for R12
  dual_strobe_counter #(.WIDTH(4), .DECADE(1'b1)) i_stage0 (
    .clk(clk), .rstN(rstN), .upStrobe(cUp), .downStrobe(cDown),
    .masterClr(cClr), .loadN(1'b1), .presetVal(4'd0),
    .countQ(dig0), .carryN(car0), .borrowN(bor0));

  dual_strobe_counter #(.WIDTH(4), .DECADE(1'b1)) i_stage1 (
    .clk(clk), .rstN(rstN), .upStrobe(car0), .downStrobe(bor0),
    .masterClr(cClr), .loadN(1'b1), .presetVal(4'd0),
    .countQ(dig1), .carryN(car1), .borrowN(bor1));

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference for the two single-stage instances (index 0 decade, 1 binary)
  int topV[2] = '{9, 15};
  int mCnt[2];
  int upHist[2][$];
  int dnHist[2][$];

  function automatic int lastUp(int k);
    return upHist[k][upHist[k].size()-1];
  endfunction
  function automatic int lastDn(int k);
    return dnHist[k][dnHist[k].size()-1];
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rstN) begin
        mCnt[k] = 0;
        upHist[k] = '{1, 1, 1};
        dnHist[k] = '{1, 1, 1};
      end else begin
        // history: [0]=previous level, [1]=synchronized level, [2]=first flop
        bit uRise, dRise;
        uRise = upHist[k][1] == 1 && upHist[k][0] == 0;
        dRise = dnHist[k][1] == 1 && dnHist[k][0] == 0;
        if (clrS) mCnt[k] = 0;
        else if (!loadS) mCnt[k] = int'(presetS);
        else if (uRise && !dRise && dnHist[k][1] == 1)
          mCnt[k] = (mCnt[k] >= topV[k]) ? 0 : mCnt[k] + 1;
        else if (dRise && !uRise && upHist[k][1] == 1)
          mCnt[k] = (mCnt[k] == 0 || mCnt[k] > topV[k]) ? topV[k] : mCnt[k] - 1;
        void'(upHist[k].pop_front());
        void'(dnHist[k].pop_front());
        upHist[k].push_back(int'(upS));
        dnHist[k].push_back(int'(downS));
      end
    end
  end

  // Per-cycle comparison, a quarter period after each rising edge
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rstN) begin
      int expCarA, expBorA, expCarB, expBorB;
      expCarA = (upHist[0][1] == 0 && mCnt[0] == 9) ? 0 : 1;
      expBorA = (dnHist[0][1] == 0 && mCnt[0] == 0) ? 0 : 1;
      expCarB = (upHist[1][1] == 0 && mCnt[1] == 15) ? 0 : 1;
      expBorB = (dnHist[1][1] == 0 && mCnt[1] == 0) ? 0 : 1;
      check(reqTag, int'(cntA), mCnt[0], "decade count");
      check(reqTag, int'(cntB), mCnt[1], "binary count");
      check("R9",  int'(carA), expCarA, "decade carryN");
      check("R9",  int'(carB), expCarB, "binary carryN");
      check("R10", int'(borA), expBorA, "decade borrowN");
      check("R10", int'(borB), expBorB, "binary borrowN");
    end
  end

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseUp(int n);
    for (int i = 0; i < n; i++) begin
      upS = 1'b0; waitN(4);
      upS = 1'b1; waitN(4);
    end
  endtask

  task automatic pulseDown(int n);
    for (int i = 0; i < n; i++) begin
      downS = 1'b0; waitN(4);
      downS = 1'b1; waitN(4);
    end
  endtask

  task automatic loadVal(int v);
    presetS = 4'(v); loadS = 1'b0; waitN(2);
    loadS = 1'b1; waitN(1);
  endtask

  task automatic cascadePulse(bit up, int n);
    for (int i = 0; i < n; i++) begin
      if (up) cUp = 1'b0; else cDown = 1'b0;
      waitN(4);
      cUp = 1'b1; cDown = 1'b1;
      waitN(4);
    end
  endtask

  initial begin
    int net;
    // R1: reset state
    waitN(3);
    check("R1", int'(cntA), 0, "count in reset");
    check("R1", int'(carA), 1, "carryN in reset");
    check("R1", int'(borA), 1, "borrowN in reset");
    check("R1", int'(cntB), 0, "binary count in reset");
    rstN = 1'b1; waitN(2);

    // R7: load holds against strobes
    reqTag = "R7";
    presetS = 4'd7; loadS = 1'b0;
    pulseUp(1);
    check("R7", int'(cntA), 7, "load overrides up strobe");
    loadS = 1'b1; waitN(2);

    // R2 and R8: count up through the decade wrap
    reqTag = "R2";
    pulseUp(3);
    check("R8", int'(cntA), 0, "decade wrap 9->0");
    check("R2", int'(cntB), 10, "binary increments");

    reqTag = "R3";
    pulseDown(1);
    check("R8", int'(cntA), 9, "decade wrap 0->9");
    check("R3", int'(cntB), 9, "binary decrement");
    pulseDown(2);
    check("R3", int'(cntA), 7, "decade decrement");

    // R4: up edge while down is low does nothing
    reqTag = "R4";
    downS = 1'b0; waitN(4);
    pulseUp(1);
    check("R4", int'(cntA), 7, "up edge with down low ignored");
    check("R4", int'(cntB), 7, "binary up edge with down low ignored");
    downS = 1'b1; waitN(4);
    check("R3", int'(cntA), 6, "down release steps down");

    // R5: simultaneous edges hold
    reqTag = "R5";
    upS = 1'b0; downS = 1'b0; waitN(4);
    upS = 1'b1; downS = 1'b1; waitN(4);
    check("R5", int'(cntA), 6, "coincident edges hold");
    check("R5", int'(cntB), 6, "binary coincident edges hold");

    // R6: clear beats load
    reqTag = "R6";
    presetS = 4'd5; loadS = 1'b0; clrS = 1'b1; waitN(2);
    check("R6", int'(cntA), 0, "clear beats load");
    clrS = 1'b0; loadS = 1'b1; waitN(2);

    // R8: down from zero
    reqTag = "R8";
    pulseDown(1);
    check("R8", int'(cntA), 9, "decade 0 down to 9");
    check("R8", int'(cntB), 15, "binary 0 down to 15");
    pulseUp(1);
    check("R8", int'(cntB), 0, "binary 15 up to 0");

    // R9: carry low only in the low half at top
    reqTag = "R9";
    loadVal(9);
    upS = 1'b0; waitN(4);
    check("R9", int'(carA), 0, "decade carry low at 9");
    check("R9", int'(carB), 1, "binary carry high at 9");
    upS = 1'b1; waitN(4);
    check("R9", int'(carA), 1, "carry returns high");
    check("R8", int'(cntA), 0, "carry edge wraps");

    // R10: borrow low at zero
    reqTag = "R10";
    clrS = 1'b1; waitN(1); clrS = 1'b0;
    downS = 1'b0; waitN(4);
    check("R10", int'(borA), 0, "decade borrow low at 0");
    check("R10", int'(borB), 0, "binary borrow low at 0");
    downS = 1'b1; waitN(4);
    check("R10", int'(borA), 1, "borrow returns high");
    check("R8", int'(cntB), 15, "borrow edge wraps");

    // R11: illegal decade states recover in one step
    reqTag = "R11";
    loadVal(12);
    check("R11", int'(cntA), 12, "illegal value loaded");
    pulseUp(1);
    check("R11", int'(cntA), 0, "12 up goes to 0");
    check("R11", int'(cntB), 13, "binary 12 up");
    loadVal(14);
    pulseDown(1);
    check("R11", int'(cntA), 9, "14 down goes to 9");
    loadVal(15);
    pulseUp(1);
    check("R11", int'(cntA), 0, "15 up goes to 0");

    // R12: two-stage cascade
    reqTag = "R12";
    cClr = 1'b1; waitN(2); cClr = 1'b0; waitN(2);
    net = 0;
    cascadePulse(1'b1, 23); net += 23; waitN(8);
    check("R12", int'(dig0), net % 10, "units after 23 up");
    check("R12", int'(dig1), net / 10, "tens after 23 up");
    cascadePulse(1'b0, 5); net -= 5; waitN(8);
    check("R12", int'(dig0), net % 10, "units after 5 down");
    check("R12", int'(dig1), net / 10, "tens after 5 down");
    cascadePulse(1'b1, 84); net = (net + 84) % 100; waitN(8);
    check("R12", int'(dig0), net % 10, "units after wrap");
    check("R12", int'(dig1), net / 10, "tens after wrap");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule